// File: doc/BRIEF.md
# Counter CSR Access Permission Checker

This block decides whether a read of one of the user-level counter CSRs (cycle, time, instret, hpmcounter3 through hpmcounter31, and the high-half version of each) may go ahead. It looks at the current privilege level, whether virtualization is active, whether the supervisor extension is implemented, the CSR address, and the machine, hypervisor and supervisor counter-enable words. From these it returns a verdict: no exception, illegal-instruction, or virtual-instruction fault. A separate flag tells the caller that the address does not belong to a counter CSR, so the checker has nothing to say about it.

The checks run in a fixed order. The machine-level enable is tested first. The checks on the virtualized path come next. The supervisor-level check for plain user mode comes last. A missing supervisor enable therefore gives a virtual-instruction fault in virtualized user mode and an illegal-instruction exception in plain user mode. With the default parameters, a request is sampled on a valid strobe and its verdict appears one cycle later. A parameter gives a purely combinational variant instead.

Top module: `ctrperm`

## Requirements
- R1: Addresses 0xC00 to 0xC1F (low halves) and 0xC80 to 0xC9F (high halves) are counter CSRs. The enable bit index is the address's low five bits: cycle is 0, time is 1, instret is 2, hpmcounterN is N. Both halves of a counter use the same index.
- R2: For any address outside both ranges, na_o is 1 and the verdict is 0 (none). For addresses inside the ranges, na_o is 0.
- R3: Privilege is encoded 2'b00 user, 2'b01 supervisor, 2'b11 machine. The value 2'b10 is treated as below machine. Below machine, if the counter's machine enable bit is 0, the verdict is 1 (illegal-instruction). This check overrides every other check.
- R4: If virtualization is active, privilege is below machine, the machine check passed, and the hypervisor enable bit is 0, the verdict is 2 (virtual-instruction fault).
- R5: If virtualization is active, privilege is user, the machine check passed, and the supervisor enable bit is 0, the verdict is 2.
- R6: If the supervisor extension is present, privilege is user, the machine and virtualization checks passed, and the supervisor enable bit is 0, the verdict is 1.
- R7: If the supervisor extension is absent and virtualization is inactive, the supervisor enable bits have no effect on the verdict.
- R8: In machine mode the verdict is always 0, whatever the enable words and the virtualization flag hold.
- R9: The verdict is never 3.
- R10: In the registered variant, a request is sampled on a clock edge where req_valid_i is 1. Its verdict, na_o and verdict_valid_o=1 appear after that edge. On edges where req_valid_i is 0, verdict_valid_o is 0 and the verdict and na_o hold their previous values.
- R11: While reset is asserted, the verdict is 0, na_o is 0 and verdict_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Virtualization active |
| s_present_i | input | 1 | Supervisor extension implemented |
| csr_addr_i | input | 12 | CSR address |
| men_i | input | 32 | Machine counter-enable word |
| hen_i | input | 32 | Hypervisor counter-enable word |
| sen_i | input | 32 | Supervisor counter-enable word |
| verdict_o | output | 2 | 0 none, 1 illegal-instruction, 2 virtual-instruction fault |
| na_o | output | 1 | Address is not a counter CSR |
| verdict_valid_o | output | 1 | Verdict corresponds to the previous request |

## Verification
The assertions check these properties on every cycle:
- The verdict never takes the value 3.
- A not-applicable flag always comes with no exception.
- The valid output follows the request strobe with one cycle of latency.
- Machine-mode requests always pass.
- A missing machine enable below machine mode always gives illegal-instruction.
- A virtual-instruction fault only ever follows a virtualized request.

Some behaviour can only be shown by the bench's scenarios:
- The full priority order across the hypervisor and supervisor enables.
- The split between plain user mode and virtualized user mode.
- The fact that the supervisor word is ignored when the extension is absent.
- The address decode at the edges of both ranges.

To show these, the bench sweeps privilege, virtualization, extension presence and all eight enable combinations for several counters.

// File: rtl/ctrperm_pkg.sv
package ctrperm_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_ILL  = 2'd1,
    VERD_VIRT = 2'd2
  } verdict_e;

  typedef struct packed {
    logic     na;
    verdict_e verdict;
  } result_t;

endpackage

// File: rtl/ctrperm_decode.sv
module ctrperm_decode #(
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 5,
  parameter int LO_BASE = 12'hC00,
  parameter int HI_BASE = 12'hC80
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [(1<<IDX_W)-1:0] men_i,
  input  logic [(1<<IDX_W)-1:0] hen_i,
  input  logic [(1<<IDX_W)-1:0] sen_i,
  output logic                hit_o,
  output logic                m_bit_o,
  output logic                h_bit_o,
  output logic                s_bit_o
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_BASE);
  localparam logic [TAG_W-1:0]  LO_TAG = LO_A[ADDR_W-1:IDX_W];
  localparam logic [TAG_W-1:0]  HI_TAG = HI_A[ADDR_W-1:IDX_W];

  logic [TAG_W-1:0] tag;
  logic [IDX_W-1:0] idx;

  always_comb begin
    tag     = addr_i[ADDR_W-1:IDX_W];
    idx     = addr_i[IDX_W-1:0];
    hit_o   = (tag == LO_TAG) || (tag == HI_TAG);
    m_bit_o = men_i[idx];
    h_bit_o = hen_i[idx];
    s_bit_o = sen_i[idx];
  end
endmodule

// File: rtl/ctrperm_policy.sv
module ctrperm_policy
  import ctrperm_pkg::*;
(
  input  priv_e   priv_i,
  input  logic    virt_i,
  input  logic    s_present_i,
  input  logic    hit_i,
  input  logic    m_bit_i,
  input  logic    h_bit_i,
  input  logic    s_bit_i,
  output result_t res_o
);
  logic below_m, is_user, virt_eff;

  always_comb begin
    below_m  = (priv_i != PRIV_M);
    is_user  = (priv_i == PRIV_U);
    virt_eff = virt_i && below_m;
    res_o.na      = !hit_i;
    res_o.verdict = VERD_NONE;
    if (hit_i) begin
      if (below_m && !m_bit_i) begin
        res_o.verdict = VERD_ILL;
      end else if (virt_eff && (!h_bit_i || (is_user && !s_bit_i))) begin
        res_o.verdict = VERD_VIRT;
      end else if (s_present_i && is_user && !s_bit_i) begin
        res_o.verdict = VERD_ILL;
      end
    end
  end
endmodule

// File: rtl/ctrperm_stage.sv
module ctrperm_stage
  import ctrperm_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid_i,
  input  result_t res_i,
  output result_t res_o,
  output logic    valid_o
);
  generate
    if (REGISTERED) begin : g_reg
      result_t res_d, res_q;
      logic    vld_q;

      always_comb begin
        res_d = res_q;
        if (valid_i) res_d = res_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q <= '{na: 1'b0, verdict: VERD_NONE};
          vld_q <= 1'b0;
        end else begin
          res_q <= res_d;
          vld_q <= valid_i;
        end
      end

      assign res_o   = res_q;
      assign valid_o = vld_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign res_o   = res_i;
      assign valid_o = valid_i;
    end
  endgenerate
endmodule

// File: rtl/ctrperm.sv
module ctrperm
  import ctrperm_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 5,
  parameter int LO_BASE    = 12'hC00,
  parameter int HI_BASE    = 12'hC80,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  input  logic [1:0]            priv_i,
  input  logic                  virt_i,
  input  logic                  s_present_i,
  input  logic [ADDR_W-1:0]     csr_addr_i,
  input  logic [(1<<IDX_W)-1:0] men_i,
  input  logic [(1<<IDX_W)-1:0] hen_i,
  input  logic [(1<<IDX_W)-1:0] sen_i,
  output logic [1:0]            verdict_o,
  output logic                  na_o,
  output logic                  verdict_valid_o
);
  logic    hit, m_bit, h_bit, s_bit;
  result_t res_c, res_r;

  ctrperm_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
  ) u_decode (
    .addr_i (csr_addr_i),
    .men_i  (men_i),
    .hen_i  (hen_i),
    .sen_i  (sen_i),
    .hit_o  (hit),
    .m_bit_o(m_bit),
    .h_bit_o(h_bit),
    .s_bit_o(s_bit)
  );

  ctrperm_policy u_policy (
    .priv_i     (priv_e'(priv_i)),
    .virt_i     (virt_i),
    .s_present_i(s_present_i),
    .hit_i      (hit),
    .m_bit_i    (m_bit),
    .h_bit_i    (h_bit),
    .s_bit_i    (s_bit),
    .res_o      (res_c)
  );

  ctrperm_stage #(.REGISTERED(REGISTERED)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(req_valid_i),
    .res_i  (res_c),
    .res_o  (res_r),
    .valid_o(verdict_valid_o)
  );

  assign verdict_o = res_r.verdict;
  assign na_o      = res_r.na;
endmodule

// File: rtl/ctrperm_chk.sv
module ctrperm_chk #(
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 5,
  parameter bit REGISTERED = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid_i,
  input logic [1:0]            priv_i,
  input logic                  virt_i,
  input logic [ADDR_W-1:0]     csr_addr_i,
  input logic [(1<<IDX_W)-1:0] men_i,
  input logic [1:0]            verdict_o,
  input logic                  na_o,
  input logic                  verdict_valid_o
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  logic m_off_low;
  assign m_off_low = (priv_i != 2'b11) && !men_i[csr_addr_i[IDX_W-1:0]];

  p_no_code3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_o != 2'd3);

  p_na_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    na_o |-> (verdict_o == 2'd0));

  generate
    if (REGISTERED) begin : g_seq
      p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (verdict_valid_o == $past(req_valid_i)));

      p_mach_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(req_valid_i) && $past(priv_i) == 2'b11) |-> (verdict_o == 2'd0));

      p_m_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(req_valid_i) && $past(m_off_low) && !na_o) |-> (verdict_o == 2'd1));

      p_virt_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && verdict_valid_o && verdict_o == 2'd2) |-> $past(virt_i));
    end else begin : g_imm
      always_comb begin
        if (rst_n && priv_i == 2'b11) p_mach_pass_r8: assert (verdict_o == 2'd0);
        if (rst_n && m_off_low && !na_o) p_m_first_r3: assert (verdict_o == 2'd1);
        if (rst_n && verdict_o == 2'd2) p_virt_src_r4: assert (virt_i);
        p_valid_lat_r10: assert (verdict_valid_o == req_valid_i);
      end
    end
  endgenerate
endmodule

bind ctrperm ctrperm_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .REGISTERED(REGISTERED)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid_i    (req_valid_i),
  .priv_i         (priv_i),
  .virt_i         (virt_i),
  .csr_addr_i     (csr_addr_i),
  .men_i          (men_i),
  .verdict_o      (verdict_o),
  .na_o           (na_o),
  .verdict_valid_o(verdict_valid_o)
);

// File: tb/ctrperm_bench.sv
module ctrperm_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [1:0]  priv_i;
  logic        virt_i;
  logic        s_present_i;
  logic [11:0] csr_addr_i;
  logic [31:0] men_i, hen_i, sen_i;
  logic [1:0]  verdict_o;
  logic        na_o;
  logic        verdict_valid_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ctrperm u_ctrperm (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .priv_i(priv_i),
    .virt_i(virt_i), .s_present_i(s_present_i), .csr_addr_i(csr_addr_i),
    .men_i(men_i), .hen_i(hen_i), .sen_i(sen_i), .verdict_o(verdict_o),
    .na_o(na_o), .verdict_valid_o(verdict_valid_o)
  );

  function automatic bit ref_hit(logic [11:0] a);
    return (a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F);
  endfunction

  function automatic logic [1:0] ref_verdict(logic [1:0] p, logic v, logic sp,
                                             logic [11:0] a, logic [31:0] m,
                                             logic [31:0] h, logic [31:0] s);
    int i;
    if (!ref_hit(a)) return 2'd0;
    i = int'(a[4:0]);
    if (p == 2'b11) return 2'd0;
    if (!m[i]) return 2'd1;
    if (v && (!h[i] || (p == 2'b00 && !s[i]))) return 2'd2;
    if (sp && p == 2'b00 && !s[i]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (priv=%0d virt=%0d s=%0d addr=%h)",
               req, act, exp, priv_i, virt_i, s_present_i, csr_addr_i);
    end
  endtask

  task automatic apply(string req, logic [1:0] p, logic v, logic sp, logic [11:0] a,
                       logic [31:0] m, logic [31:0] h, logic [31:0] s);
    @(negedge clk);
    priv_i = p; virt_i = v; s_present_i = sp; csr_addr_i = a;
    men_i = m; hen_i = h; sen_i = s; req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(req, {1'b0, verdict_valid_o, verdict_o}, {1'b0, 1'b1, ref_verdict(p, v, sp, a, m, h, s)});
    check(req, {3'b0, na_o}, {3'b0, !ref_hit(a)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] lv;
    logic       ln;
    logic [11:0] tst_addr [5];
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; req_valid_i = 1'b1; priv_i = 2'b00; virt_i = 1'b0;
    s_present_i = 1'b1; csr_addr_i = 12'hC00; men_i = '0; hen_i = '0; sen_i = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {1'b0, na_o, verdict_o}, 4'h0);
    check("R11", {3'b0, verdict_valid_o}, 4'h0);
    req_valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 decode edges, R2 out-of-range
    apply("R1", 2'b00, 1'b0, 1'b1, 12'hC1F, 32'h7FFF_FFFF, '1, '1);
    apply("R1", 2'b00, 1'b0, 1'b1, 12'hC9F, 32'h7FFF_FFFF, '1, '1);
    apply("R1", 2'b01, 1'b0, 1'b1, 12'hC82, 32'hFFFF_FFFB, '1, '1);
    apply("R2", 2'b00, 1'b0, 1'b1, 12'hC20, '0, '0, '0);
    apply("R2", 2'b00, 1'b1, 1'b1, 12'hBFF, '0, '0, '0);
    apply("R2", 2'b01, 1'b0, 1'b1, 12'hCA0, '0, '0, '0);
    // R7 S absent, non-virt: sen ignored
    apply("R7", 2'b00, 1'b0, 1'b0, 12'hC00, '1, '1, '0);
    // R6 S present, user, sen bit 0
    apply("R6", 2'b00, 1'b0, 1'b1, 12'hC00, '1, '1, '0);
    // R5 virt user sen 0 gives fault 2, not 1
    apply("R5", 2'b00, 1'b1, 1'b1, 12'hC01, '1, '1, '0);
    // R4 virt supervisor hen 0
    apply("R4", 2'b01, 1'b1, 1'b0, 12'hC85, '1, '0, '1);
    // R3 machine bit overrides everything
    apply("R3", 2'b10, 1'b1, 1'b1, 12'hC03, '0, '0, '0);
    // R8 machine with everything off
    apply("R8", 2'b11, 1'b1, 1'b1, 12'hC02, '0, '0, '0);

    // R10 hold when valid low
    apply("R10", 2'b00, 1'b0, 1'b1, 12'hC00, '0, '1, '1);
    lv = verdict_o; ln = na_o;
    @(negedge clk);
    priv_i = 2'b11;
    @(negedge clk);
    check("R10", {1'b0, verdict_valid_o, verdict_o}, {1'b0, 1'b0, lv});
    check("R10", {3'b0, na_o}, {3'b0, ln});

    // Exhaustive sweep: R3 R4 R5 R6 R7 R8 across privileges and enable triples
    tst_addr[0] = 12'hC00; tst_addr[1] = 12'hC01; tst_addr[2] = 12'hC81;
    tst_addr[3] = 12'hC07; tst_addr[4] = 12'hC9F;
    for (int ai = 0; ai < 5; ai++)
      for (int p = 0; p < 4; p++)
        for (int v = 0; v < 2; v++)
          for (int sp = 0; sp < 2; sp++)
            for (int e = 0; e < 8; e++) begin
              logic [31:0] bit_mask;
              bit_mask = 32'h1 << tst_addr[ai][4:0];
              apply("R3_R8_sweep", 2'(p), 1'(v), 1'(sp), tst_addr[ai],
                    e[0] ? bit_mask : ~bit_mask, e[1] ? bit_mask : ~bit_mask,
                    e[2] ? bit_mask : ~bit_mask);
            end

    // Random mix: R1 R2 R9
    for (int n = 0; n < 2000; n++) begin
      logic [11:0] a;
      a = ($urandom % 3 == 0) ? 12'($urandom) :
          {($urandom % 2 == 0) ? 7'h60 : 7'h64, 5'($urandom)};
      apply("R9_random", 2'($urandom), 1'($urandom), 1'($urandom), a,
            $urandom, $urandom, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule